// File: doc/BRIEF.md
# Video Sync Conditioner and Regenerator

This block cleans up the horizontal and vertical sync signals of an analog video input. Each sync has two candidate sources. Horizontal sync comes from a dedicated pin or from a sync-on-green slicer. Vertical sync comes from a dedicated pin or from a composite sync separator. A register picks the source, or the block picks it from recent edge activity. Input polarity is normalised to active-high. The polarity is either forced by a register or found by measuring which level is held for the shorter time. All inputs pass through a two-flop synchroniser before any edge is detected.

The horizontal output is rebuilt from each leading edge as a pulse whose width is programmed in pixel clocks. The vertical output has three modes. It can follow the input level. It can be resampled only at horizontal leading edges, which filters out glitches and aligns it to the line timing. It can also be rebuilt as a pulse whose width is programmed in horizontal periods. Each output has a programmable active level.

Four 8-bit registers are loaded through a plain parallel write strobe. The block has no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `sync_regen`

## Requirements
- R1: After reset both outputs are low. The register defaults are: horizontal control 0x18, horizontal width 32, vertical control 0x18, vertical width 10. With these defaults, a pin Hsync pulse yields a 32-clock pulse and a pin Vsync pulse is passed through level for level.
- R2: Register address 1 holds the Hsync width W, from 1 to 255. A leading edge of the selected, normalised Hsync produces an output pulse that starts 3 clocks after the input edge is driven. The pulse lasts exactly W clocks, whatever the length of the input pulse.
- R3: Control bit 3 (horizontal control at address 0, vertical control at address 2) sets the output active level: 1 means active high. When idle, each output rests at the inverse of its bit 3.
- R4: When the Hsync width register holds 0, no Hsync output pulse is produced.
- R5: Horizontal control bit 7 = 1 forces the source chosen by bit 6: 0 is the pin, 1 is sync-on-green. Pulses on the source that is not chosen have no effect on the output.
- R6: With horizontal control bit 7 = 0, a source counts as active for ACT_TIMEOUT clocks after its last synchronised edge. The pin is used when only the pin is active. Sync-on-green is used when the pin is inactive. When both are active, bit 6 decides.
- R7: With bit 5 = 0, the input polarity is inferred once per period: the level held for fewer clocks is treated as the active pulse. At reset the inferred polarity is active high.
- R8: Bit 5 = 1 forces the input polarity from bit 4 (1 = active high). This applies to both sources of that sync.
- R9: With vertical control bits 2 and 1 both 0, the Vsync output follows the normalised input level with a latency of 2 clocks.
- R10: Vertical control bit 1 = 1 turns a Vsync leading edge into a pulse. The pulse starts 3 clocks after the edge is driven and ends on the N-th following Hsync leading edge, where N is the value at address 3. When N is 0, no pulse is produced.
- R11: Vertical control bit 2 = 1 updates the Vsync level only at Hsync leading edges, 3 clocks after the Hsync edge is driven. A Vsync pulse that ends before the next Hsync edge is dropped.
- R12: Vertical control bit 7 = 1 forces the source chosen by bit 6: 0 is the pin, 1 is the separator. With bit 7 = 0, the pin is used while it is active and the separator is used otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 horizontal control, 1 horizontal width, 2 vertical control, 3 vertical width |
| cfg_wdata | input | 8 | Register write data |
| hs_pin | input | 1 | Horizontal sync from dedicated pin |
| hs_sog | input | 1 | Horizontal sync from sync-on-green slicer |
| vs_pin | input | 1 | Vertical sync from dedicated pin |
| vs_sep | input | 1 | Vertical sync from sync separator |
| hs_out | output | 1 | Regenerated horizontal sync |
| vs_out | output | 1 | Conditioned vertical sync |

## Verification
Each stimulus is driven just after a falling clock edge, which counts as cycle 0. Outputs are sampled at every later falling edge. The Hsync pulse is due in cycle 3. The Vsync level in follow mode is due in cycle 2. A regenerated Vsync pulse begins in cycle 3 and ends 3 cycles after the Hsync edge that closes its count is driven. A filtered Vsync changes 3 cycles after the Hsync edge that samples it. Each check records the first active cycle and the number of active cycles in a fixed window. Both are compared against these offsets and the programmed widths, so an error of a single cycle in either start or length is reported.

// File: rtl/sync_regen_pkg.sv
package sync_regen_pkg;
  localparam int CFG_W = 8;

  typedef struct packed {
    logic src_ovr;   // 7
    logic src_alt;   // 6
    logic pol_ovr;   // 5
    logic in_hi;     // 4
    logic out_hi;    // 3
    logic filt_en;   // 2
    logic dur_en;    // 1
    logic spare;     // 0
  } sync_ctl_t;

  localparam logic [1:0] ADR_HCTL = 2'd0;
  localparam logic [1:0] ADR_HWID = 2'd1;
  localparam logic [1:0] ADR_VCTL = 2'd2;
  localparam logic [1:0] ADR_VWID = 2'd3;

  localparam logic [CFG_W-1:0] RST_HCTL = 8'h18;
  localparam logic [CFG_W-1:0] RST_HWID = 8'd32;
  localparam logic [CFG_W-1:0] RST_VCTL = 8'h18;
  localparam logic [CFG_W-1:0] RST_VWID = 8'd10;
endpackage

// File: rtl/sync_regen_regs.sv
module sync_regen_regs
  import sync_regen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [CFG_W-1:0] wdata,
  output sync_ctl_t        hctl,
  output logic [CFG_W-1:0] hwid,
  output sync_ctl_t        vctl,
  output logic [CFG_W-1:0] vwid
);
  localparam int NREG = 4;

  function automatic logic [CFG_W-1:0] rst_val(input int idx);
    case (idx)
      0:       return RST_HCTL;
      1:       return RST_HWID;
      2:       return RST_VCTL;
      default: return RST_VWID;
    endcase
  endfunction

  logic [CFG_W-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs[i] <= rst_val(i);
      else if (we && (addr == 2'(i)))     regs[i] <= wdata;
    end
  end

  assign hctl = sync_ctl_t'(regs[ADR_HCTL]);
  assign hwid = regs[ADR_HWID];
  assign vctl = sync_ctl_t'(regs[ADR_VCTL]);
  assign vwid = regs[ADR_VWID];
endmodule

// File: rtl/sync_regen_cond.sv
module sync_regen_cond #(
  parameter int TIMEOUT  = 4096,
  parameter int MEAS_W   = 12,
  parameter bit BOTH_SEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic alt,
  input  logic src_ovr,
  input  logic src_alt,
  input  logic pol_ovr,
  input  logic pol_hi,
  output logic norm,
  output logic lead
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0]     T_MAX = TW'(TIMEOUT);
  localparam logic [MEAS_W-1:0] M_MAX = '1;

  logic [1:0] s1, s2, act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {alt, pin};
      s2 <= s1;
    end
  end

  // activity timer per source: index 0 pin, 1 alternate
  for (genvar i = 0; i < 2; i++) begin : g_src
    logic [TW-1:0] tmr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tmr <= T_MAX;
      else if (s1[i] ^ s2[i])    tmr <= '0;
      else if (tmr != T_MAX)     tmr <= tmr + TW'(1);
    end
    assign act[i] = (tmr != T_MAX);

    // R6: an edge marks the source active on the next cycle
    p_edge_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s1[i] ^ s2[i]) |=> act[i]);
  end

  logic use_alt;
  always_comb begin
    if (src_ovr)                use_alt = src_alt;
    else if (act[0] && act[1])  use_alt = BOTH_SEL ? src_alt : 1'b0;
    else                        use_alt = ~act[0];
  end

  logic raw, raw_d, rise, det_hi, pol, norm_d;
  logic [MEAS_W-1:0] hi_cnt, lo_cnt;

  assign raw  = use_alt ? s2[1] : s2[0];
  assign rise = raw & ~raw_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_d  <= 1'b0;
      hi_cnt <= '0;
      lo_cnt <= '0;
      det_hi <= 1'b1;
    end else begin
      raw_d <= raw;
      if (rise) begin
        det_hi <= (hi_cnt < lo_cnt);
        hi_cnt <= MEAS_W'(1);
        lo_cnt <= '0;
      end else if (raw) begin
        if (hi_cnt != M_MAX) hi_cnt <= hi_cnt + MEAS_W'(1);
      end else begin
        if (lo_cnt != M_MAX) lo_cnt <= lo_cnt + MEAS_W'(1);
      end
    end
  end

  assign pol  = pol_ovr ? pol_hi : det_hi;
  assign norm = pol ? raw : ~raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) norm_d <= 1'b0;
    else        norm_d <= norm;
  end

  assign lead = norm & ~norm_d;

  // R7: a period with a short high phase settles on active high
  p_detect_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && (hi_cnt < lo_cnt)) |=> det_hi);
endmodule

// File: rtl/sync_regen_pulse.sv
module sync_regen_pulse #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= (len != '0);
      cnt    <= len;
    end else if (active && tick) begin
      if (cnt <= LEN_W'(1)) active <= 1'b0;
      else                  cnt    <= cnt - LEN_W'(1);
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (len != '0)) |=> active);

  p_zero_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (len == '0)) |=> !active);

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> !active);
endmodule

// File: rtl/sync_regen.sv
module sync_regen
  import sync_regen_pkg::*;
#(
  parameter int ACT_TIMEOUT = 4096,
  parameter int MEAS_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             hs_pin,
  input  logic             hs_sog,
  input  logic             vs_pin,
  input  logic             vs_sep,
  output logic             hs_out,
  output logic             vs_out
);
  sync_ctl_t        hctl, vctl;
  logic [CFG_W-1:0] hwid, vwid;

  sync_regen_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .hctl  (hctl),
    .hwid  (hwid),
    .vctl  (vctl),
    .vwid  (vwid)
  );

  logic hs_norm, hs_lead, vn, vs_lead_raw;

  sync_regen_cond #(.TIMEOUT(ACT_TIMEOUT), .MEAS_W(MEAS_W), .BOTH_SEL(1'b1)) u_hcond (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (hs_pin),
    .alt     (hs_sog),
    .src_ovr (hctl.src_ovr),
    .src_alt (hctl.src_alt),
    .pol_ovr (hctl.pol_ovr),
    .pol_hi  (hctl.in_hi),
    .norm    (hs_norm),
    .lead    (hs_lead)
  );

  sync_regen_cond #(.TIMEOUT(ACT_TIMEOUT), .MEAS_W(MEAS_W), .BOTH_SEL(1'b0)) u_vcond (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (vs_pin),
    .alt     (vs_sep),
    .src_ovr (vctl.src_ovr),
    .src_alt (vctl.src_alt),
    .pol_ovr (vctl.pol_ovr),
    .pol_hi  (vctl.in_hi),
    .norm    (vn),
    .lead    (vs_lead_raw)
  );

  // horizontal pulse, width in pixel clocks
  logic hs_act;
  sync_regen_pulse #(.LEN_W(CFG_W)) u_hpulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (hs_lead),
    .tick   (1'b1),
    .len    (hwid),
    .active (hs_act)
  );

  // vertical filter: resample at horizontal leading edges
  logic vf_q, vf, vf_d, vlead;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vf_q <= 1'b0;
      vf_d <= 1'b0;
    end else begin
      if (!vctl.filt_en || hs_lead) vf_q <= vn;
      vf_d <= vf;
    end
  end
  assign vf    = vctl.filt_en ? vf_q : vn;
  assign vlead = vf & ~vf_d;

  // vertical pulse, width in horizontal periods
  logic vs_act;
  sync_regen_pulse #(.LEN_W(CFG_W)) u_vpulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (vctl.dur_en && vlead),
    .tick   (hs_lead),
    .len    (vwid),
    .active (vs_act)
  );

  logic vs_lvl;
  assign vs_lvl = vctl.dur_en ? vs_act : vf;
  assign hs_out = hctl.out_hi ? hs_act : ~hs_act;
  assign vs_out = vctl.out_hi ? vs_lvl : ~vs_lvl;

  logic unused_bits;
  assign unused_bits = ^{hctl.filt_en, hctl.dur_en, hctl.spare, vctl.spare,
                         hs_norm, vs_lead_raw};

  // R11: with filtering on, the vertical level moves only on a horizontal edge
  p_filt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vctl.filt_en && !hs_lead) |=> $stable(vf_q));

  // R10: a vertical edge in pulse mode with nonzero width starts the pulse
  p_regen_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vctl.dur_en && vlead && (vwid != '0)) |=> vs_act);
endmodule

// File: tb/sync_regen_tb.sv
module sync_regen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       hs_pin = 1'b0, hs_sog = 1'b0, vs_pin = 1'b0, vs_sep = 1'b0;
  logic       hs_out, vs_out;

  int checks = 0;
  int errors = 0;
  int f, c, f2, c2;

  always #4 clk = ~clk;

  sync_regen #(.ACT_TIMEOUT(64), .MEAS_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hs_pin(hs_pin), .hs_sog(hs_sog),
    .vs_pin(vs_pin), .vs_sep(vs_sep), .hs_out(hs_out), .vs_out(vs_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(input int which, input logic v);
    case (which)
      0: hs_pin = v;
      1: hs_sog = v;
      2: vs_pin = v;
      default: vs_sep = v;
    endcase
  endtask

  // drive an input active for len cycles; report first active cycle and count
  task automatic measure(input int which, input logic in_hi, input int len,
                         input int win, input logic out_hi, input bit is_vs,
                         output int first, output int cnt);
    logic o;
    first = -1; cnt = 0;
    @(negedge clk);
    set_in(which, in_hi);
    for (int k = 1; k <= win; k++) begin
      @(negedge clk);
      o = is_vs ? vs_out : hs_out;
      if (o == out_hi) begin
        cnt++;
        if (first < 0) first = k;
      end
      if (k == len) set_in(which, ~in_hi);
    end
  endtask

  task automatic hs_train(input int first_d, input int period, input int n);
    @(negedge clk);
    repeat (first_d) @(negedge clk);
    for (int j = 0; j < n; j++) begin
      hs_pin = 1'b1;
      @(negedge clk);
      hs_pin = 1'b0;
      if (j < n - 1) repeat (period - 1) @(negedge clk);
    end
  endtask

  task automatic pol_train(input logic act_hi, input int n);
    for (int j = 0; j < n; j++) begin
      hs_pin = act_hi;
      repeat (3) @(negedge clk);
      hs_pin = ~act_hi;
      repeat (17) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and defaults
    chk("R1 hs_out after reset", int'(hs_out), 0);
    chk("R1 vs_out after reset", int'(vs_out), 0);
    measure(0, 1'b1, 4, 45, 1'b1, 1'b0, f, c);
    chk("R1 default hs start", f, 3);
    chk("R1 default hs width 32", c, 32);
    idle(20);
    measure(2, 1'b1, 5, 12, 1'b1, 1'b1, f, c);
    chk("R1 default vs start", f, 2);
    chk("R1 default vs follows", c, 5);

    // R2 R3 R4 R8 sweep of Hsync width and polarities
    for (int ih = 0; ih < 2; ih++)
      for (int oh = 0; oh < 2; oh++)
        for (int w = 0; w <= 24; w++) begin
          set_in(0, ih == 0);
          wr(2'd1, 8'(w));
          wr(2'd0, 8'(8'hA0 | (ih << 4) | (oh << 3)));
          idle(40);
          chk("R3 hs idle level", int'(hs_out), (oh == 0) ? 1 : 0);
          measure(0, logic'(ih), 1 + (w % 5), w + 8, logic'(oh), 1'b0, f, c);
          if (w == 0) chk("R4 zero width no pulse", c, 0);
          else begin
            chk("R2 R8 hs start", f, 3);
            chk("R2 R8 hs width", c, w);
          end
        end
    set_in(0, 1'b0);

    // R9 R8 R3 Vsync follow mode
    for (int ih = 0; ih < 2; ih++)
      for (int oh = 0; oh < 2; oh++)
        for (int len = 1; len <= 8; len++) begin
          set_in(2, ih == 0);
          wr(2'd2, 8'(8'hA0 | (ih << 4) | (oh << 3)));
          idle(10);
          chk("R3 vs idle level", int'(vs_out), (oh == 0) ? 1 : 0);
          measure(2, logic'(ih), len, len + 6, logic'(oh), 1'b1, f, c);
          chk("R9 vs follow start", f, 2);
          chk("R9 vs follow length", c, len);
        end
    set_in(2, 1'b0);

    // R10 Vsync regeneration in Hsync periods
    wr(2'd0, 8'h98);
    wr(2'd1, 8'd2);
    wr(2'd2, 8'hBA);
    for (int vw = 0; vw <= 6; vw++) begin
      wr(2'd3, 8'(vw));
      idle(20);
      fork
        measure(2, 1'b1, 2, 70, 1'b1, 1'b1, f, c);
        hs_train(10, 8, vw + 2);
      join
      if (vw == 0) chk("R10 zero count no pulse", c, 0);
      else begin
        chk("R10 regen start", f, 3);
        chk("R10 regen length", c, 10 + 8 * (vw - 1));
      end
    end

    // R11 Vsync filter aligned to Hsync
    wr(2'd2, 8'hBC);
    idle(20);
    fork
      measure(2, 1'b1, 20, 40, 1'b1, 1'b1, f, c);
      hs_train(5, 8, 5);
    join
    chk("R11 filtered start", f, 8);
    chk("R11 filtered length", c, 16);
    idle(20);
    fork
      measure(2, 1'b1, 3, 20, 1'b1, 1'b1, f, c);
      hs_train(10, 8, 1);
    join
    chk("R11 short glitch dropped", c, 0);

    // R12 Vsync source selection
    wr(2'd2, 8'h38);
    idle(100);
    measure(3, 1'b1, 4, 10, 1'b1, 1'b1, f, c);
    chk("R12 auto uses separator start", f, 2);
    chk("R12 auto uses separator length", c, 4);
    wr(2'd2, 8'hF8);
    idle(10);
    measure(2, 1'b1, 4, 10, 1'b1, 1'b1, f, c);
    chk("R12 pin ignored under override", c, 0);
    measure(3, 1'b1, 4, 10, 1'b1, 1'b1, f, c);
    chk("R12 separator under override", c, 4);

    // R5 Hsync source override
    wr(2'd1, 8'd4);
    wr(2'd0, 8'hF8);
    idle(20);
    measure(1, 1'b1, 2, 12, 1'b1, 1'b0, f, c);
    chk("R5 sog start", f, 3);
    chk("R5 sog width", c, 4);
    measure(0, 1'b1, 2, 12, 1'b1, 1'b0, f, c);
    chk("R5 pin ignored", c, 0);
    wr(2'd0, 8'hB8);
    idle(10);
    measure(1, 1'b1, 2, 12, 1'b1, 1'b0, f, c);
    chk("R5 sog ignored", c, 0);

    // R6 automatic Hsync source
    wr(2'd0, 8'h38);
    idle(100);
    measure(1, 1'b1, 2, 12, 1'b1, 1'b0, f, c);
    chk("R6 idle pin uses sog start", f, 3);
    chk("R6 idle pin uses sog width", c, 4);
    measure(0, 1'b1, 2, 12, 1'b1, 1'b0, f, c);
    chk("R6 active pin start", f, 3);
    chk("R6 active pin width", c, 4);
    measure(1, 1'b1, 2, 12, 1'b1, 1'b0, f2, c2);
    chk("R6 both active bit6=0 ignores sog", c2, 0);
    wr(2'd0, 8'h78);
    measure(1, 1'b1, 2, 12, 1'b1, 1'b0, f, c);
    chk("R6 both active bit6=1 uses sog", c, 4);

    // R7 automatic input polarity
    wr(2'd0, 8'h88);
    hs_pin = 1'b1;
    idle(20);
    pol_train(1'b0, 4);
    measure(0, 1'b0, 3, 12, 1'b1, 1'b0, f, c);
    chk("R7 active low start", f, 3);
    chk("R7 active low width", c, 4);
    hs_pin = 1'b0;
    idle(20);
    pol_train(1'b1, 4);
    measure(0, 1'b1, 3, 12, 1'b1, 1'b0, f, c);
    chk("R7 active high start", f, 3);
    chk("R7 active high width", c, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule